// File: doc/BRIEF.md
# Storage Bounds Guard

This block screens every main storage reference against a software-loaded limits word. The word holds two windows: one for instruction-side references and one for data-side references. Each window has a lower and an upper page bound, and a page is 512 words. The block takes the 18-bit effective address, the kind of access and the protection bits of the processor state. When a checked reference falls outside its window, the block raises a one-cycle fault strobe for the interrupt logic. Under guard mode it also raises the same strobe when a control-register address belongs to the executive-only groups.

The block sits beside the address path. The executive loads the limits word with a dedicated strobe before it hands control to a program. The interrupt logic reacts to the fault strobe one cycle after the offending reference. Relocation, interrupt vectoring and the storage array are handled elsewhere.

Top module: `storage_bounds_guard`

## Requirements
- R1: The limits word resets to all zeros and changes only on a clock edge where `limLoad` is 1, taking `limData`. A reference presented on the same edge as a load is judged against the previous limits.
- R2: Field layout of the limits word: bits [35:27] are the instruction upper bound, [26:18] the instruction lower bound, [17:9] the data upper bound and [8:0] the data lower bound.
- R3: With `guardOn` = 0 the fault strobe never rises, whatever the address, access kind or control-register reference.
- R4: With `guardOn` = 1 and `writeOnly` = 0, every access kind is checked: fetch, jump, read and write.
- R5: With `guardOn` = 1 and `writeOnly` = 1, only writes are checked. Fetch, jump and read references raise no fault.
- R6: Access kind encoding: 2'b00 fetch, 2'b01 jump, 2'b10 read, 2'b11 write. Fetch and jump use the instruction window, and read and write use the data window. The page is address bits [17:9], and a page is in range when lower <= page <= upper, with both ends inclusive.
- R7: A window whose lower bound is greater than its upper bound is empty, so every checked reference against it faults.
- R8: With `compatMode` = 1, address bits [17:16] are treated as zero before the check.
- R9: With `guardOn` = 1, a control-register reference (`crefValid` = 1) to octal 040–077, octal 100 or octal 120–177 faults. Octal 000–037 and 101–117 do not fault.
- R10: `faultPulse` is registered. It is 1 for exactly the cycle after a faulting reference is presented, and 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| limLoad | input | 1 | Load strobe for the limits word |
| limData | input | 36 | New limits word |
| reqValid | input | 1 | A storage reference is presented |
| reqAddr | input | 18 | Effective storage address |
| reqKind | input | 2 | Access kind (fetch, jump, read, write) |
| guardOn | input | 1 | Guard mode enable from processor state |
| writeOnly | input | 1 | Write-only protection select |
| compatMode | input | 1 | Strip address bits [17:16] |
| crefValid | input | 1 | A control-register reference is presented |
| crefAddr | input | 7 | Control-register address |
| faultPulse | output | 1 | Protection fault strobe, one cycle |

## Verification
The bench builds the block with its default parameters: an 18-bit address, 9-bit bounds, a 16-bit compatibility range and 7-bit control-register addresses. With these values the bench can reach every page at both window edges, the two address bits removed in compatibility mode, and the whole control-register space, including the borders at octal 037/040, 077/100/101 and 117/120. Random loads with lower bounds above upper bounds exercise the empty-window case together with all three protection modes.

// File: rtl/guard_pkg.sv
package guard_pkg;
  typedef enum logic [1:0] {
    ACC_FETCH = 2'b00,
    ACC_JUMP  = 2'b01,
    ACC_READ  = 2'b10,
    ACC_WRITE = 2'b11
  } acc_kind_e;

  // strobes from control to datapath
  typedef struct packed {
    logic loadLim;
    logic selInstr;
    logic stripHigh;
  } guard_strobe_t;
endpackage

// File: rtl/guard_datapath.sv
module guard_datapath
  import guard_pkg::*;
#(
  parameter int ADDR_W  = 18,
  parameter int BOUND_W = 9,
  parameter int KEEP_W  = 16
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  guard_strobe_t          strobe,
  input  logic [4*BOUND_W-1:0]   limData,
  input  logic [ADDR_W-1:0]      reqAddr,
  output logic                   areaHit
);
  localparam int LIM_W = 4 * BOUND_W;
  localparam int NUM_AREAS = 2;   // index 0 data, 1 instruction
  localparam logic [ADDR_W-1:0] KEEP_MASK =
    {{(ADDR_W-KEEP_W){1'b0}}, {KEEP_W{1'b1}}};

  logic [LIM_W-1:0]   limReg;
  logic [ADDR_W-1:0]  effAddr;
  logic [BOUND_W-1:0] page;
  logic [NUM_AREAS-1:0] hitVec;

  always_ff @(posedge clk) begin
    if (!rstN)               limReg <= '0;
    else if (strobe.loadLim) limReg <= limData;
  end

  assign effAddr = strobe.stripHigh ? (reqAddr & KEEP_MASK) : reqAddr;
  assign page    = effAddr[ADDR_W-1 -: BOUND_W];

  for (genvar g = 0; g < NUM_AREAS; g++) begin : g_area
    logic [BOUND_W-1:0] lowB, upB;
    assign lowB = limReg[g*2*BOUND_W +: BOUND_W];
    assign upB  = limReg[g*2*BOUND_W+BOUND_W +: BOUND_W];
    assign hitVec[g] = (page >= lowB) && (page <= upB);

    // R7: empty window never reports a hit
    p_empty_area_r7: assert property (@(posedge clk) disable iff (!rstN)
      (lowB > upB) |-> !hitVec[g]);
  end

  assign areaHit = strobe.selInstr ? hitVec[1] : hitVec[0];

  p_limit_load_r1: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadLim |=> (limReg == $past(limData)));
  p_limit_hold_r1: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.loadLim |=> $stable(limReg));
endmodule

// File: rtl/guard_ctrl.sv
module guard_ctrl
  import guard_pkg::*;
#(
  parameter int CREG_W = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              limLoad,
  input  logic              reqValid,
  input  logic [1:0]        reqKind,
  input  logic              guardOn,
  input  logic              writeOnly,
  input  logic              compatMode,
  input  logic              crefValid,
  input  logic [CREG_W-1:0] crefAddr,
  input  logic              areaHit,
  output guard_strobe_t     strobe,
  output logic              faultPulse
);
  // executive-only control register groups (octal 040-077, 100, 120-177)
  localparam logic [CREG_W-1:0] ACR_LO   = CREG_W'(32);
  localparam logic [CREG_W-1:0] ACR_HI   = CREG_W'(63);
  localparam logic [CREG_W-1:0] CLOCK_RG = CREG_W'(64);
  localparam logic [CREG_W-1:0] EXEC_LO  = CREG_W'(80);

  acc_kind_e kind;
  logic isInstrSide, needCheck, storeFault, crefProt, crefFault, faultNext;

  assign kind        = acc_kind_e'(reqKind);
  assign isInstrSide = (kind == ACC_FETCH) || (kind == ACC_JUMP);
  assign needCheck   = !writeOnly || (kind == ACC_WRITE);

  assign strobe.loadLim   = limLoad;
  assign strobe.selInstr  = isInstrSide;
  assign strobe.stripHigh = compatMode;

  assign storeFault = guardOn && reqValid && needCheck && !areaHit;
  assign crefProt   = ((crefAddr >= ACR_LO) && (crefAddr <= ACR_HI)) ||
                      (crefAddr == CLOCK_RG) || (crefAddr >= EXEC_LO);
  assign crefFault  = guardOn && crefValid && crefProt;
  assign faultNext  = storeFault || crefFault;

  always_ff @(posedge clk) begin
    if (!rstN) faultPulse <= 1'b0;
    else       faultPulse <= faultNext;
  end

  p_open_quiet_r3: assert property (@(posedge clk) disable iff (!rstN)
    !guardOn |=> !faultPulse);
  p_wo_skip_r5: assert property (@(posedge clk) disable iff (!rstN)
    (guardOn && writeOnly && !crefValid && (kind != ACC_WRITE)) |=> !faultPulse);
  p_low_creg_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!reqValid && crefValid && (crefAddr < ACR_LO)) |=> !faultPulse);
  p_fault_cause_r10: assert property (@(posedge clk) disable iff (!rstN)
    (!reqValid && !crefValid) |=> !faultPulse);
endmodule

// File: rtl/storage_bounds_guard.sv
module storage_bounds_guard
  import guard_pkg::*;
#(
  parameter int ADDR_W  = 18,
  parameter int BOUND_W = 9,
  parameter int KEEP_W  = 16,
  parameter int CREG_W  = 7
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 limLoad,
  input  logic [4*BOUND_W-1:0] limData,
  input  logic                 reqValid,
  input  logic [ADDR_W-1:0]    reqAddr,
  input  logic [1:0]           reqKind,
  input  logic                 guardOn,
  input  logic                 writeOnly,
  input  logic                 compatMode,
  input  logic                 crefValid,
  input  logic [CREG_W-1:0]    crefAddr,
  output logic                 faultPulse
);
  guard_strobe_t strobe;
  logic areaHit;

  guard_ctrl #(.CREG_W(CREG_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .limLoad(limLoad), .reqValid(reqValid),
    .reqKind(reqKind), .guardOn(guardOn), .writeOnly(writeOnly),
    .compatMode(compatMode), .crefValid(crefValid), .crefAddr(crefAddr),
    .areaHit(areaHit), .strobe(strobe), .faultPulse(faultPulse)
  );

  guard_datapath #(.ADDR_W(ADDR_W), .BOUND_W(BOUND_W), .KEEP_W(KEEP_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .limData(limData),
    .reqAddr(reqAddr), .areaHit(areaHit)
  );
endmodule

// File: tb/storage_bounds_guard_test.sv
module storage_bounds_guard_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        limLoad = 1'b0;
  logic [35:0] limData = '0;
  logic        reqValid = 1'b0;
  logic [17:0] reqAddr = '0;
  logic [1:0]  reqKind = '0;
  logic        guardOn = 1'b0, writeOnly = 1'b0, compatMode = 1'b0;
  logic        crefValid = 1'b0;
  logic [6:0]  crefAddr = '0;
  logic        faultPulse;

  int checks = 0;
  int failures = 0;
  longint modelLim = 0;

  always #4 clk = ~clk;   // 125 MHz

  storage_bounds_guard uut (
    .clk(clk), .rstN(rstN), .limLoad(limLoad), .limData(limData),
    .reqValid(reqValid), .reqAddr(reqAddr), .reqKind(reqKind),
    .guardOn(guardOn), .writeOnly(writeOnly), .compatMode(compatMode),
    .crefValid(crefValid), .crefAddr(crefAddr), .faultPulse(faultPulse)
  );

  function automatic bit model(longint lim, bit rv, int addr, int kind, bit g,
                               bit wo, bit cp, bit cv, int ca);
    int a, pg, lo, up;
    bit f = 0;
    if (!g) return 0;
    if (cv && ((ca >= 32 && ca <= 63) || ca == 64 || ca >= 80)) f = 1;
    if (rv && (!wo || kind == 3)) begin
      a  = cp ? (addr % 65536) : addr;
      pg = a / 512;
      if (kind < 2) begin lo = int'((lim >> 18) % 512); up = int'((lim >> 27) % 512); end
      else          begin lo = int'(lim % 512);         up = int'((lim >> 9) % 512);  end
      if (!(lo <= pg && pg <= up)) f = 1;
    end
    return f;
  endfunction

  task automatic step(input string tag, input bit ld, input longint ldv,
                      input bit rv, input int addr, input int kind,
                      input bit g, input bit wo, input bit cp,
                      input bit cv, input int ca);
    bit exp;
    limLoad = ld; limData = 36'(ldv); reqValid = rv; reqAddr = 18'(addr);
    reqKind = 2'(kind); guardOn = g; writeOnly = wo; compatMode = cp;
    crefValid = cv; crefAddr = 7'(ca);
    exp = model(modelLim, rv, addr, kind, g, wo, cp, cv, ca);
    @(posedge clk);
    if (ld) modelLim = ldv;
    @(negedge clk);
    checks++;
    if (faultPulse !== exp) begin
      failures++;
      $display("FAIL %s: faultPulse=%0b expected=%0b (addr=%0h kind=%0d)",
               tag, faultPulse, exp, addr, kind);
    end
  endtask

  function automatic longint mkLim(int iu, int il, int du, int dl);
    return (longint'(iu) << 27) | (longint'(il) << 18) | (longint'(du) << 9) | longint'(dl);
  endfunction

  initial begin
    #2_000_000;
    failures++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;
    checks++;
    if (faultPulse !== 1'b0) begin
      failures++; $display("FAIL R10: reset faultPulse=%0b expected=0", faultPulse);
    end
    // R1: reset limits are zero, so only page 0 is in range
    step("R1", 0, 0, 1, 18'h001ff, 2, 1, 0, 0, 0, 0);
    step("R1", 0, 0, 1, 18'h00200, 2, 1, 0, 0, 0, 0);
    // R1: load and use on same edge sees old limits
    step("R1", 1, mkLim(20, 10, 8, 4), 1, 5*512, 2, 1, 0, 0, 0, 0);
    step("R1", 0, 0, 1, 5*512, 2, 1, 0, 0, 0, 0);
    // R2/R6: inclusive edges of each window
    step("R2", 0, 0, 1, 10*512, 0, 1, 0, 0, 0, 0);
    step("R2", 0, 0, 1, 20*512+511, 1, 1, 0, 0, 0, 0);
    step("R6", 0, 0, 1, 9*512+511, 0, 1, 0, 0, 0, 0);
    step("R6", 0, 0, 1, 21*512, 1, 1, 0, 0, 0, 0);
    step("R6", 0, 0, 1, 4*512, 3, 1, 0, 0, 0, 0);
    step("R6", 0, 0, 1, 9*512, 3, 1, 0, 0, 0, 0);
    step("R6", 0, 0, 1, 15*512, 2, 1, 0, 0, 0, 0);
    // R4: full mode checks fetch out of range
    step("R4", 0, 0, 1, 2*512, 0, 1, 0, 0, 0, 0);
    // R5: write-only mode
    step("R5", 0, 0, 1, 2*512, 0, 1, 1, 0, 0, 0);
    step("R5", 0, 0, 1, 50*512, 2, 1, 1, 0, 0, 0);
    step("R5", 0, 0, 1, 50*512, 3, 1, 1, 0, 0, 0);
    // R3: open mode
    step("R3", 0, 0, 1, 200*512, 3, 0, 0, 0, 1, 40);
    // R7: empty data window
    step("R7", 1, mkLim(20, 10, 3, 7), 0, 0, 0, 1, 0, 0, 0, 0);
    step("R7", 0, 0, 1, 5*512, 2, 1, 0, 0, 0, 0);
    // R8: compatibility strip
    step("R8", 1, mkLim(20, 10, 8, 4), 1, 18'h30000 + 5*512, 2, 1, 0, 1, 0, 0);
    step("R8", 0, 0, 1, 18'h30000 + 5*512, 2, 1, 0, 0, 0, 0);
    // R9: control register borders
    begin
      int cr[10] = '{31, 32, 63, 64, 65, 79, 80, 127, 0, 70};
      foreach (cr[i]) step("R9", 0, 0, 0, 0, 0, 1, 0, 0, 1, cr[i]);
    end
    // R10: back-to-back faults then quiet
    step("R10", 0, 0, 1, 100*512, 2, 1, 0, 0, 0, 0);
    step("R10", 0, 0, 1, 100*512, 2, 1, 0, 0, 0, 0);
    step("R10", 0, 0, 0, 100*512, 2, 1, 0, 0, 0, 0);
    // random mix
    for (int n = 0; n < 600; n++) begin
      bit ld = ($urandom % 8) == 0;
      longint v = mkLim(int'($urandom % 512), int'($urandom % 512),
                        int'($urandom % 512), int'($urandom % 512));
      step("R4", ld, v, 1'($urandom), int'($urandom % 262144), int'($urandom % 4),
           ($urandom % 4) != 0, 1'($urandom), 1'($urandom),
           ($urandom % 4) == 0, int'($urandom % 128));
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule